// File: doc/BRIEF.md
# Label-Based Minimum Check Node

This block is the check node unit of a finite-alphabet LDPC decoder. It takes the variable-to-check messages of all edges of one check node at once. Each message is a short signed quantizer label of a few bits. For every edge it forms the extrinsic check-to-variable label from the other edges only. The magnitude is the smallest label magnitude among the other edges. The sign is the parity of the other edges' signs.

The labels are indices of a non-uniform quantizer, so the node does no arithmetic on their values. It applies no scaling and no offset, and it never converts to two's complement. Outputs stay in sign-magnitude form and go straight onto the routing network towards the variable nodes. The node degree and the label width are parameters. The result is captured in one register stage, so the unit drops into a pipelined, unrolled decoder.

Top module: `lbl_min_check_node`

## Requirements
- R1: Every label on the inputs and outputs is Q bits wide (default 3; 3 and 4 are supported) in sign-magnitude form. Bit Q-1 is the sign, with 1 meaning negative. Bits Q-2..0 hold the unsigned magnitude. Edge e occupies bits e*Q+Q-1 down to e*Q of the flat buses, and the default degree DC is 6.
- R2: The output magnitude of edge e is the minimum of the input magnitudes of all edges other than e.
- R3: When exactly one edge holds the smallest magnitude, that edge receives the second-smallest magnitude and every other edge receives the smallest. When two or more edges tie for the smallest, every edge receives that value.
- R4: When the output magnitude of edge e is non-zero, its sign bit is the XOR of the sign bits of all other edges. Input sign bits count as given, even on a zero magnitude.
- R5: An output magnitude of zero always carries sign bit 0.
- R6: No scaling or offset is applied. The largest magnitude (all magnitude bits set) passes through unchanged when every other edge carries it.
- R7: The output for an input vector appears after exactly one rising clock edge. While rst is high at a rising edge, every output label is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| v2c_lbl | input | DC*Q | Incoming variable-to-check labels, edge e at bits e*Q+Q-1..e*Q |
| c2v_lbl | output | DC*Q | Registered outgoing check-to-variable labels, same layout |

## Verification
The hardest case to reach is a tie for the smallest magnitude. A tie puts the index logic and the second-minimum logic at their boundary. Random labels seldom produce a tie at the largest magnitude, and seldom place a unique minimum on the last edge. The stimulus therefore sweeps every magnitude combination at degree 6 with random signs, which covers all tie patterns and every minimum position. Directed vectors add the all-maximum case, the all-zero case and zero magnitudes with negative signs.

// File: rtl/lmcn_pkg.sv
package lmcn_pkg;
  // Width needed to index n items (at least one bit).
  function automatic int idx_width(input int n);
    int w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

  localparam int DEF_DEGREE = 6;
  localparam int DEF_LABEL_W = 3;
endpackage

// File: rtl/lmcn_min_pair.sv
// Finds the smallest magnitude, the edge that holds it and the runner-up.
module lmcn_min_pair #(
  parameter int DC = 6,
  parameter int MW = 2,
  parameter int IW = 3
) (
  input  logic [DC*MW-1:0] mags,
  output logic [MW-1:0]    min_lo,
  output logic [MW-1:0]    min_hi,
  output logic [IW-1:0]    min_idx
);
  always_comb begin
    logic [MW-1:0] m;
    min_lo  = '1;
    min_hi  = '1;
    min_idx = '0;
    for (int i = 0; i < DC; i++) begin
      m = mags[i*MW +: MW];
      if (m < min_lo) begin
        min_hi  = min_lo;
        min_lo  = m;
        min_idx = IW'(i);
      end else if (m < min_hi) begin
        min_hi = m;
      end
    end
  end

  // R3 ordering between the two reported magnitudes, and the index must point at the smallest
  always_comb begin
    a_r3_min_order: assert (min_lo <= min_hi);
    a_r3_idx_holds_min: assert (mags[min_idx*MW +: MW] == min_lo);
  end
endmodule

// File: rtl/lmcn_sign_parity.sv
// XOR of all edge sign bits.
module lmcn_sign_parity #(
  parameter int DC = 6
) (
  input  logic [DC-1:0] signs,
  output logic          parity
);
  assign parity = ^signs;
endmodule

// File: rtl/lmcn_edge_out.sv
// Forms the extrinsic label of one edge from the shared search results.
module lmcn_edge_out #(
  parameter int EDGE = 0,
  parameter int MW = 2,
  parameter int IW = 3
) (
  input  logic [MW-1:0] min_lo,
  input  logic [MW-1:0] min_hi,
  input  logic [IW-1:0] min_idx,
  input  logic          parity,
  input  logic          own_sign,
  output logic [MW:0]   lbl
);
  logic [MW-1:0] mag;
  logic          sgn;

  assign mag = (min_idx == IW'(EDGE)) ? min_hi : min_lo;
  assign sgn = (mag == '0) ? 1'b0 : (parity ^ own_sign);
  assign lbl = {sgn, mag};

  // R5 a zero magnitude never leaves with the sign set
  always_comb begin
    a_r5_no_neg_zero: assert (!(lbl[MW-1:0] == '0 && lbl[MW]));
  end
endmodule

// File: rtl/lbl_min_check_node.sv
module lbl_min_check_node
  import lmcn_pkg::*;
#(
  parameter int DC = DEF_DEGREE,
  parameter int Q  = DEF_LABEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DC*Q-1:0] v2c_lbl,
  output logic [DC*Q-1:0] c2v_lbl
);
  localparam int MW = Q - 1;
  localparam int IW = idx_width(DC);

  logic [DC*MW-1:0] in_mag;
  logic [DC-1:0]    in_sgn;
  logic [MW-1:0]    min_lo, min_hi;
  logic [IW-1:0]    min_idx;
  logic             parity;
  logic [DC*Q-1:0]  nxt_lbl;
  logic             live;

  for (genvar e = 0; e < DC; e++) begin : g_split
    assign in_mag[e*MW +: MW] = v2c_lbl[e*Q +: MW];
    assign in_sgn[e]          = v2c_lbl[e*Q + Q - 1];
  end

  lmcn_min_pair #(.DC(DC), .MW(MW), .IW(IW)) u_min (
    .mags   (in_mag),
    .min_lo (min_lo),
    .min_hi (min_hi),
    .min_idx(min_idx)
  );

  lmcn_sign_parity #(.DC(DC)) u_par (
    .signs (in_sgn),
    .parity(parity)
  );

  for (genvar e = 0; e < DC; e++) begin : g_edge
    lmcn_edge_out #(.EDGE(e), .MW(MW), .IW(IW)) u_out (
      .min_lo  (min_lo),
      .min_hi  (min_hi),
      .min_idx (min_idx),
      .parity  (parity),
      .own_sign(in_sgn[e]),
      .lbl     (nxt_lbl[e*Q +: Q])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c2v_lbl <= '0;
      live    <= 1'b0;
    end else begin
      c2v_lbl <= nxt_lbl;
      live    <= 1'b1;
    end
  end

  // R7 outputs are cleared on the edge after reset is seen
  a_r7_reset_clears: assert property (@(posedge clk) rst |=> c2v_lbl == '0);

  for (genvar j = 0; j < DC; j++) begin : g_chk
    // R4 sign of a non-zero output equals parity of the other edges' inputs one cycle earlier
    a_r4_sign_parity: assert property (@(posedge clk) disable iff (rst)
      (live && c2v_lbl[j*Q +: MW] != '0) |->
        c2v_lbl[j*Q + Q - 1] == ((^$past(in_sgn)) ^ $past(in_sgn[j])));
    for (genvar k = 0; k < DC; k++) begin : g_other
      if (k != j) begin : g_ne
        // R2 output magnitude is no larger than any other edge's input magnitude
        a_r2_mag_bound: assert property (@(posedge clk) disable iff (rst)
          live |-> c2v_lbl[j*Q +: MW] <= $past(in_mag[k*MW +: MW]));
      end
    end
  end
endmodule

// File: tb/lbl_min_check_node_tb_top.sv
module lbl_min_check_node_tb_top;
  localparam int DC = 6;
  localparam int Q  = 3;
  localparam int MW = Q - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DC*Q-1:0] v2c_lbl = '0;
  logic [DC*Q-1:0] c2v_lbl;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  lbl_min_check_node #(.DC(DC), .Q(Q)) dut_i (
    .clk(clk), .rst(rst), .v2c_lbl(v2c_lbl), .c2v_lbl(c2v_lbl)
  );

  // Brute-force expected label for edge j.
  function automatic logic [Q-1:0] ref_lbl(input logic [DC*Q-1:0] v, input int j);
    logic [MW-1:0] m;
    logic s;
    m = '1;
    s = 1'b0;
    for (int k = 0; k < DC; k++) begin
      if (k != j) begin
        if (v[k*Q +: MW] < m) m = v[k*Q +: MW];
        s = s ^ v[k*Q + Q - 1];
      end
    end
    if (m == '0) s = 1'b0;
    return {s, m};
  endfunction

  // Drive at a falling edge, sample at the next falling edge (one register).
  task automatic apply(input logic [DC*Q-1:0] v, input string tag);
    logic [Q-1:0] e, a;
    bit bad;
    v2c_lbl = v;
    @(negedge clk);
    checks++;
    bad = 0;
    for (int j = 0; j < DC; j++) begin
      e = ref_lbl(v, j);
      a = c2v_lbl[j*Q +: Q];
      if (!bad && a != e) begin
        bad = 1;
        errors++;
        $display("FAIL %s (%s) edge %0d in=%h actual=%b expected=%b",
                 (a[MW-1:0] != e[MW-1:0]) ? "R2" : (e[MW-1:0] == 0 ? "R5" : "R4"),
                 tag, j, v, a, e);
      end
    end
  endtask

  function automatic logic [DC*Q-1:0] rand_vec();
    logic [DC*Q-1:0] v;
    for (int k = 0; k < DC; k++) v[k*Q +: Q] = Q'($urandom);
    return v;
  endfunction

  initial begin
    logic [DC*Q-1:0] v;
    void'($urandom(32'h5eed1234));
    @(negedge clk);
    @(negedge clk);
    // R7 reset state
    checks++;
    if (c2v_lbl !== '0) begin
      errors++;
      $display("FAIL R7 reset actual=%h expected=0", c2v_lbl);
    end
    rst = 1'b0;

    // R6 all maximum magnitudes, mixed signs
    apply({3'b111, 3'b011, 3'b111, 3'b011, 3'b011, 3'b111}, "R6 all max");
    // R5 all zero magnitudes with negative signs
    apply({DC{3'b100}}, "R5 neg zero in");
    // R3 unique minimum on the last edge
    apply({3'b001, 3'b011, 3'b010, 3'b111, 3'b110, 3'b011}, "R3 min last");
    // R3 unique minimum on edge 0
    apply({3'b011, 3'b010, 3'b111, 3'b011, 3'b110, 3'b000}, "R3 min first");
    // R3 tie at the smallest value
    apply({3'b101, 3'b011, 3'b001, 3'b111, 3'b110, 3'b011}, "R3 tie");
    // R4 single zero among non-zero, odd negative count
    apply({3'b110, 3'b001, 3'b111, 3'b000, 3'b010, 3'b101}, "R4 one zero");
    // R1 edge layout: one negative edge, all others max
    apply({3'b011, 3'b011, 3'b011, 3'b101, 3'b011, 3'b011}, "R1 layout");

    // R2 R3 every magnitude combination with random signs
    for (int n = 0; n < (1 << (DC*MW)); n++) begin
      for (int k = 0; k < DC; k++) begin
        v[k*Q +: MW] = MW'(n >> (k*MW));
        v[k*Q + Q - 1] = 1'($urandom);
      end
      apply(v, "R2 sweep");
    end

    // R4 random labels
    for (int n = 0; n < 3000; n++) apply(rand_vec(), "R4 random");

    // R7 reset in the middle of traffic
    v2c_lbl = rand_vec();
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (c2v_lbl !== '0) begin
      errors++;
      $display("FAIL R7 mid reset actual=%h expected=0", c2v_lbl);
    end
    rst = 1'b0;
    apply({3'b010, 3'b111, 3'b001, 3'b011, 3'b110, 3'b010}, "R7 after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule